// File: doc/BRIEF.md
# In-Order Retirement Buffer for Out-of-Order Execution

This block tracks micro-ops from allocation to retirement in a circular buffer. The rename stage allocates one entry per cycle at the tail and gets back the entry index as the micro-op's tag. Execution units later use that tag to mark the entry complete. With the same writeback they store the result value and a fault flag. The oldest entry sits at the head and retires once it is complete. Each retirement writes the entry's destination register and value into the architectural register file. Retirement follows program order no matter in which order the results arrive.

A fault recorded on an entry has no effect until that entry becomes the oldest. At that point the buffer reports an exception carrying the entry index and drops every entry in flight. The faulting entry writes nothing to the register file.

A combinational read port lets the rename stage look up an entry by index. It returns the result of any entry that is complete but not yet retired, so younger micro-ops can take it as an operand. Depth, data width and register index width are parameters. The default depth is 96 entries.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty. `empty`=1, `allocReady`=1 and `allocIdx`=0, and neither `rfWrEn` nor `excValid` is asserted.
- R2: An allocation with `allocValid`=1 and `allocReady`=1 takes the index shown on `allocIdx` in that cycle. The next free index is then the current one plus 1, wrapping from DEPTH-1 to 0. At most one entry is allocated per cycle.
- R3: An occupancy counter tracks the buffer. When it equals DEPTH, `allocReady` is 0 and a request on `allocValid` allocates nothing: `allocIdx` does not move.
- R4: A writeback (`wbValid`=1) to an allocated entry marks it complete and stores `wbData` and `wbExc` in it.
- R5: A writeback to an index that is not allocated has no effect. That index stays not ready on the read port, and nothing retires.
- R6: The read port is combinational. `rdReady` is 1 exactly when entry `rdIdx` is allocated and complete, and then `rdData` carries its stored result. For an incomplete entry `rdReady` is 0.
- R7: Only the head entry can retire, and only when it is allocated and complete. A complete younger entry waits behind an incomplete head.
- R8: When the head retires without a fault, `rfWrEn` is 1 in that same cycle, with `rfWrReg`/`rfWrData` set to the entry's destination and value. The head then advances by one, so at most one entry retires per cycle. `rfWrEn` and `excValid` are never both 1.
- R9: When the head is complete with its fault flag set, `excValid` is 1 with `excIdx` = head index, and `rfWrEn` stays 0. In the next cycle the buffer is empty and `allocIdx` is 0. `allocReady` is 0 during the exception cycle.
- R10: A fault on an entry that is not the head raises no exception until every older entry has retired.
- R11: In a cycle with both a retirement and an allocation, occupancy is unchanged. When the buffer is full, the full condition holds for that whole cycle, even if the head retires in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocation request from rename |
| allocDest | input | AREG_W | Architectural destination register of the new micro-op |
| allocReady | output | 1 | Allocation accepted this cycle if requested |
| allocIdx | output | IDX_W | Index given to the allocating micro-op |
| wbValid | input | 1 | Writeback strobe from an execution unit |
| wbIdx | input | IDX_W | Entry being completed |
| wbData | input | DATA_W | Result value |
| wbExc | input | 1 | Fault flag for the entry |
| rdIdx | input | IDX_W | Operand lookup index |
| rdReady | output | 1 | Looked-up entry holds a completed result |
| rdData | output | DATA_W | Completed result of the looked-up entry |
| rfWrEn | output | 1 | Architectural register write strobe (retirement) |
| rfWrReg | output | AREG_W | Register written on retirement |
| rfWrData | output | DATA_W | Value written on retirement |
| excValid | output | 1 | Exception from the head entry; buffer flushes |
| excIdx | output | IDX_W | Index of the faulting entry |
| empty | output | 1 | No entries in flight |

## Verification
The hardest states to reach are the full buffer and the wrap of the indices past DEPTH-1. Both are held together with a deferred fault. The stimulus retires a few entries to move the head off zero, then allocates all DEPTH entries in a row and checks each returned index. It then frees one slot and issues an allocation in the same cycle as a retirement, so the tail wraps while occupancy stays constant. Fault deferral is reached by completing a younger entry with its fault flag set while an older entry is still pending. The older entry is then completed, and the bench confirms that it retires first and that the exception appears one cycle later.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef struct packed {
    logic alloc;
    logic retire;
    logic flush;
  } robStrobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 96,
  parameter int IDX_W = 7,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             headValid,
  input  logic             headDone,
  input  logic             headExc,
  output robStrobe_t       strobe,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic [CNT_W-1:0] occupancy,
  output logic             allocReady,
  output logic             empty
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  logic headReady;
  logic full;

  assign headReady     = headValid && headDone;
  assign full          = (occupancy == FULL_CNT);
  assign empty         = (occupancy == '0);
  assign strobe.flush  = headReady && headExc;
  assign strobe.retire = headReady && !headExc;
  assign allocReady    = !full && !strobe.flush;
  assign strobe.alloc  = allocValid && allocReady;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      headIdx   <= '0;
      tailIdx   <= '0;
      occupancy <= '0;
    end else begin
      if (strobe.retire) headIdx <= stepIdx(headIdx);
      if (strobe.alloc)  tailIdx <= stepIdx(tailIdx);
      case ({strobe.alloc, strobe.retire})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
    end
  end
endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH  = 96,
  parameter int IDX_W  = 7,
  parameter int DATA_W = 32,
  parameter int AREG_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  robStrobe_t        strobe,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [IDX_W-1:0]  tailIdx,
  input  logic [AREG_W-1:0] allocDest,
  input  logic              wbValid,
  input  logic [IDX_W-1:0]  wbIdx,
  input  logic [DATA_W-1:0] wbData,
  input  logic              wbExc,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              headValid,
  output logic              headDone,
  output logic              headExc,
  output logic [AREG_W-1:0] headDest,
  output logic [DATA_W-1:0] headData,
  output logic              rdReady,
  output logic [DATA_W-1:0] rdData
);
  logic              entValid [DEPTH];
  logic              entDone  [DEPTH];
  logic              entExc   [DEPTH];
  logic [AREG_W-1:0] entDest  [DEPTH];
  logic [DATA_W-1:0] entData  [DEPTH];

  logic wbInRange, rdInRange, wbHit;

  assign wbInRange = (int'(wbIdx) < DEPTH);
  assign rdInRange = (int'(rdIdx) < DEPTH);
  assign wbHit     = wbValid && wbInRange && entValid[wbInRange ? wbIdx : '0];

  assign headValid = entValid[headIdx];
  assign headDone  = entDone[headIdx];
  assign headExc   = entExc[headIdx];
  assign headDest  = entDest[headIdx];
  assign headData  = entData[headIdx];

  assign rdReady = rdInRange && entValid[rdInRange ? rdIdx : '0]
                             && entDone[rdInRange ? rdIdx : '0];
  assign rdData  = entData[rdInRange ? rdIdx : '0];

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      for (int i = 0; i < DEPTH; i++) begin
        entValid[i] <= 1'b0;
        entDone[i]  <= 1'b0;
        entExc[i]   <= 1'b0;
      end
    end else begin
      if (strobe.alloc) begin
        entValid[tailIdx] <= 1'b1;
        entDone[tailIdx]  <= 1'b0;
        entExc[tailIdx]   <= 1'b0;
      end
      if (wbHit) begin
        entDone[wbIdx] <= 1'b1;
        entExc[wbIdx]  <= wbExc;
      end
      if (strobe.retire) entValid[headIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.alloc && !strobe.flush) entDest[tailIdx] <= allocDest;
    if (wbHit) entData[wbIdx] <= wbData;
  end
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int DEPTH  = 96,
  parameter int DATA_W = 32,
  parameter int AREG_W = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [AREG_W-1:0] allocDest,
  output logic              allocReady,
  output logic [IDX_W-1:0]  allocIdx,
  input  logic              wbValid,
  input  logic [IDX_W-1:0]  wbIdx,
  input  logic [DATA_W-1:0] wbData,
  input  logic              wbExc,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rfWrEn,
  output logic [AREG_W-1:0] rfWrReg,
  output logic [DATA_W-1:0] rfWrData,
  output logic              excValid,
  output logic [IDX_W-1:0]  excIdx,
  output logic              empty
);
  robStrobe_t        strobe;
  logic [IDX_W-1:0]  headIdx, tailIdx;
  logic [CNT_W-1:0]  occupancy;
  logic              headValid, headDone, headExc;
  logic [AREG_W-1:0] headDest;
  logic [DATA_W-1:0] headData;

  rob_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid),
    .headValid(headValid), .headDone(headDone), .headExc(headExc),
    .strobe(strobe), .headIdx(headIdx), .tailIdx(tailIdx),
    .occupancy(occupancy), .allocReady(allocReady), .empty(empty)
  );

  rob_data #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W), .AREG_W(AREG_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headIdx(headIdx), .tailIdx(tailIdx),
    .allocDest(allocDest), .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData),
    .wbExc(wbExc), .rdIdx(rdIdx), .headValid(headValid), .headDone(headDone),
    .headExc(headExc), .headDest(headDest), .headData(headData),
    .rdReady(rdReady), .rdData(rdData)
  );

  assign allocIdx = tailIdx;
  assign rfWrEn   = strobe.retire;
  assign rfWrReg  = headDest;
  assign rfWrData = headData;
  assign excValid = strobe.flush;
  assign excIdx   = headIdx;
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter int DEPTH = 96,
  parameter int IDX_W = 7,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocValid,
  input logic             allocReady,
  input logic [IDX_W-1:0] allocIdx,
  input logic             rfWrEn,
  input logic             excValid,
  input logic             empty,
  input logic [CNT_W-1:0] occupancy
);
  function automatic logic [IDX_W-1:0] wrapNext(input logic [IDX_W-1:0] idx);
    return (int'(idx) == DEPTH - 1) ? '0 : idx + 1'b1;
  endfunction

  // R3
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(occupancy) == DEPTH) |-> !allocReady);

  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(occupancy) <= DEPTH);

  // R2
  tail_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && allocReady) |=> (allocIdx == wrapNext($past(allocIdx))));

  // R8
  retire_exc_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rfWrEn && excValid));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> (empty && allocIdx == '0));

  // R7
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> (!rfWrEn && !excValid));

  // R11
  occ_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && allocReady && rfWrEn) |=> $stable(occupancy));
endmodule

bind rob_top rob_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocReady(allocReady),
  .allocIdx(allocIdx), .rfWrEn(rfWrEn), .excValid(excValid), .empty(empty),
  .occupancy(occupancy)
);

// File: tb/rob_top_tb.sv
module rob_top_tb;
  localparam int DEPTH  = 96;
  localparam int DATA_W = 32;
  localparam int AREG_W = 5;
  localparam int IDX_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 1'b0;
  logic [AREG_W-1:0] allocDest = '0;
  logic allocReady;
  logic [IDX_W-1:0] allocIdx;
  logic wbValid = 1'b0;
  logic [IDX_W-1:0] wbIdx = '0;
  logic [DATA_W-1:0] wbData = '0;
  logic wbExc = 1'b0;
  logic [IDX_W-1:0] rdIdx = '0;
  logic rdReady;
  logic [DATA_W-1:0] rdData;
  logic rfWrEn;
  logic [AREG_W-1:0] rfWrReg;
  logic [DATA_W-1:0] rfWrData;
  logic excValid;
  logic [IDX_W-1:0] excIdx;
  logic empty;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rob_top #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AREG_W(AREG_W)) u_dut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocDest(allocDest),
    .allocReady(allocReady), .allocIdx(allocIdx), .wbValid(wbValid), .wbIdx(wbIdx),
    .wbData(wbData), .wbExc(wbExc), .rdIdx(rdIdx), .rdReady(rdReady), .rdData(rdData),
    .rfWrEn(rfWrEn), .rfWrReg(rfWrReg), .rfWrData(rfWrData), .excValid(excValid),
    .excIdx(excIdx), .empty(empty)
  );

  task automatic chkEq(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic allocOne(input int dest, input int expIdx, input string req);
    allocValid = 1'b1;
    allocDest  = AREG_W'(dest);
    #1;
    chkEq({req, " allocReady"}, allocReady, 1);
    chkEq({req, " allocIdx"}, allocIdx, expIdx);
    step();
    allocValid = 1'b0;
  endtask

  task automatic writeBack(input int idx, input int data, input bit exc);
    wbValid = 1'b1;
    wbIdx   = IDX_W'(idx);
    wbData  = DATA_W'(data);
    wbExc   = exc;
    step();
    wbValid = 1'b0;
    wbExc   = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chkEq("R1 empty", empty, 1);
    chkEq("R1 allocReady", allocReady, 1);
    chkEq("R1 allocIdx", allocIdx, 0);
    chkEq("R1 rfWrEn", rfWrEn, 0);
    chkEq("R1 excValid", excValid, 0);
  endtask

  task automatic t_inOrder();
    allocOne(1, 0, "R2 a0");
    allocOne(2, 1, "R2 a1");
    allocOne(3, 2, "R2 a2");
    writeBack(2, 'hC3, 1'b0);
    chkEq("R7 younger waits", rfWrEn, 0);
    rdIdx = 2; #1;
    chkEq("R6 rdReady done", rdReady, 1);
    chkEq("R4 rdData", rdData, 'hC3);
    rdIdx = 1; #1;
    chkEq("R6 rdReady pending", rdReady, 0);
    writeBack(0, 'hA1, 1'b0);
    chkEq("R8 retire0 en", rfWrEn, 1);
    chkEq("R8 retire0 reg", rfWrReg, 1);
    chkEq("R8 retire0 data", rfWrData, 'hA1);
    writeBack(1, 'hB2, 1'b0);
    chkEq("R8 retire1 reg", rfWrReg, 2);
    chkEq("R8 retire1 data", rfWrData, 'hB2);
    step();
    chkEq("R8 retire2 en", rfWrEn, 1);
    chkEq("R8 retire2 reg", rfWrReg, 3);
    chkEq("R8 retire2 data", rfWrData, 'hC3);
    step();
    chkEq("R8 drained", empty, 1);
    chkEq("R2 tail at 3", allocIdx, 3);
  endtask

  task automatic t_ignoreWb();
    writeBack(10, 'h55, 1'b0);
    rdIdx = 10; #1;
    chkEq("R5 rdReady stays 0", rdReady, 0);
    chkEq("R5 no retire", rfWrEn, 0);
    chkEq("R5 still empty", empty, 1);
    allocOne(4, 3, "R5 a3");
    writeBack(5, 'h66, 1'b0);
    rdIdx = 5; #1;
    chkEq("R5 beyond tail ignored", rdReady, 0);
    chkEq("R5 head not done", rfWrEn, 0);
  endtask

  task automatic t_exception();
    allocOne(7, 4, "R2 a4");
    writeBack(4, 'hEE, 1'b1);
    chkEq("R10 held", excValid, 0);
    writeBack(3, 'h33, 1'b0);
    chkEq("R10 older retires", rfWrEn, 1);
    chkEq("R10 older reg", rfWrReg, 4);
    chkEq("R10 no exc yet", excValid, 0);
    step();
    chkEq("R9 excValid", excValid, 1);
    chkEq("R9 excIdx", excIdx, 4);
    chkEq("R9 no rf write", rfWrEn, 0);
    chkEq("R9 allocReady low", allocReady, 0);
    step();
    chkEq("R9 empty after", empty, 1);
    chkEq("R9 allocIdx 0", allocIdx, 0);
    chkEq("R9 exc cleared", excValid, 0);
  endtask

  task automatic t_full();
    allocOne(1, 0, "R2 p0");
    allocOne(2, 1, "R2 p1");
    writeBack(0, 'h10, 1'b0);
    writeBack(1, 'h11, 1'b0);
    step();
    chkEq("R2 head moved", empty, 1);
    for (int i = 0; i < DEPTH; i++) allocOne(i % 32, (i + 2) % DEPTH, "R2 fill");
    chkEq("R3 full refuses", allocReady, 0);
    chkEq("R3 not empty", empty, 0);
    allocValid = 1'b1; step(); allocValid = 1'b0; #1;
    chkEq("R3 idx unchanged", allocIdx, 2);
    chkEq("R3 still full", allocReady, 0);
    writeBack(2, 'h20, 1'b0);
    chkEq("R11 retire while full", rfWrEn, 1);
    chkEq("R11 full during retire", allocReady, 0);
    step();
    chkEq("R11 slot freed", allocReady, 1);
    writeBack(3, 'h21, 1'b0);
    chkEq("R11 retire pending", rfWrEn, 1);
    allocOne(9, 2, "R11 alloc+retire");
    chkEq("R11 occupancy held", allocReady, 1);
    allocOne(9, 3, "R2 wrap tail");
    chkEq("R3 full again", allocReady, 0);
    writeBack(4, 'h99, 1'b1);
    chkEq("R9 full flush", excValid, 1);
    chkEq("R9 full flush idx", excIdx, 4);
    step();
    chkEq("R9 empty after full", empty, 1);
    chkEq("R9 tail reset", allocIdx, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    t_reset();
    t_inOrder();
    t_ignoreWb();
    t_exception();
    t_full();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule